// File: doc/BRIEF.md
# Remote DMA Port Engine

This block lets a host move data between itself and a local packet memory through one data port, without addressing that memory directly. The host first programs a 16-bit start address and a 16-bit byte count through byte-wide registers. It then writes a command byte that selects a read or a write transfer. After that, each data-port access moves one byte, or one 16-bit word in word mode. The engine steps its current address and its remaining count on every access. When the count runs out, it raises a completion status bit, which the host clears by writing a one to it.

In read transfers the engine fetches the next memory location ahead of the host. The data port therefore shows a valid value before the host asks for it, and an output tells the host when that value is ready. The live address can be read back at any time. A host uses this to confirm where the engine stands, for example after a dummy read.

Top module: `rdma_port_engine`

## Requirements
- R1: Register offsets are 0x8 and 0x9 for the start address (low and high byte), 0xA and 0xB for the count (low and high byte), and 0xE bit 0 for word mode. Writing offset 0x0 with bit 1 set starts a transfer. Bits 5:3 of that byte select the kind: 001 starts a read and 010 starts a write.
- R2: Reading offset 0x8 or 0x9 returns the low or high byte of the current address. Offset 0x7 returns the status byte, and offset 0x0 returns the last command byte written. The current address is loaded from the start address when a transfer starts.
- R3: In byte mode, each accepted access adds 1 to the address and subtracts 1 from the count.
- R4: In word mode, each accepted access adds 2 to the address and subtracts 2 from the count. An odd programmed count is rounded up to the next even value.
- R5: In a read transfer, `dp_rd_ready` rises two clocks after the start edge, and again two clocks after each accepted read. `dp_rdata` then holds the memory content at the current address. In byte mode this is the byte, zero-extended. In word mode it is the little-endian word.
- R6: In a write transfer, `dp_wr` asserts `mem_we` in the same cycle, with `mem_addr` equal to the current address and `mem_wdata` equal to `dp_wdata`.
- R7: Completion status (offset 0x7, bit 6, also driven on `done_irq`) is set on the edge of the access that takes the count to zero. The transfer is then inactive. A start with a count of zero sets the status on the start edge.
- R8: Writing offset 0x7 with bit 6 set clears the completion status. Writing it with bit 6 clear leaves the status unchanged.
- R9: A command byte with bit 5 set (field 1xx) aborts any transfer. Later data-port accesses have no effect, and the completion status is not set.
- R10: A data-port access while no transfer is active leaves the address unchanged and does not write memory.
- R11: Command field 011 with the start bit starts no transfer. The address is not reloaded and data-port accesses stay ignored.
- R12: After reset the engine is idle, the completion status is 0, and the current address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational readback of offset `reg_addr` |
| dp_rd | input | 1 | Data-port read access |
| dp_wr | input | 1 | Data-port write access |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Prefetched read data |
| dp_rd_ready | output | 1 | Prefetched read data is valid |
| done_irq | output | 1 | Completion status bit |
| mem_re | output | 1 | Local memory read request (data returned one clock later) |
| mem_we | output | 1 | Local memory write strobe |
| mem_wide | output | 1 | Access covers two bytes (word mode) |
| mem_addr | output | 16 | Local memory byte address |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data, little-endian pair |

## Verification
Results fall due at different times:
- Register writes, completion status and address steps all take effect on the edge that samples the strobe.
- Memory writes appear in the same cycle as `dp_wr`.
- Read data becomes valid two edges after a start or an accepted read, because the engine passes through a fetch cycle and a memory-latency cycle.

A behavioural model in the bench keeps a countdown for that read delay. Outputs are compared on every clock, five nanoseconds after the rising edge, while inputs only change on the falling edge. Every sample therefore sees the state that follows a settled edge.

// File: rtl/rdma_pkg.sv
// Shared definitions for the remote DMA port engine: register offsets,
// command field codes and the engine state encoding.
package rdma_pkg;
    localparam logic [3:0] OFS_CMD     = 4'h0;
    localparam logic [3:0] OFS_STATUS  = 4'h7;
    localparam logic [3:0] OFS_ADDR_LO = 4'h8;
    localparam logic [3:0] OFS_ADDR_HI = 4'h9;
    localparam logic [3:0] OFS_CNT_LO  = 4'hA;
    localparam logic [3:0] OFS_CNT_HI  = 4'hB;
    localparam logic [3:0] OFS_CFG     = 4'hE;

    localparam int DONE_BIT  = 6;
    localparam int START_BIT = 1;

    localparam logic [2:0] XFER_READ  = 3'b001;
    localparam logic [2:0] XFER_WRITE = 3'b010;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_WAIT,
        ENG_READY,
        ENG_WRITE
    } eng_state_t;
endpackage

// File: rtl/rdma_regs.sv
// Host register file: holds start address, byte count, word mode, the last
// command byte and the write-1-to-clear completion flag. Decodes command
// writes into single-cycle start/abort pulses.
// Assumes ADDR_W and CNT_W are 16 (two byte registers each).
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              done_set,
    output logic              start_rd,
    output logic              start_wr,
    output logic              abort_req,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W:0]    start_cnt,
    output logic              word_mode,
    output logic              done_flag,
    output logic [7:0]        cmd_byte
);
    logic [CNT_W-1:0] cnt_reg;
    logic             cmd_hit;
    logic [2:0]       field;
    logic             clr_hit;

    // Decode a command write into start and abort pulses.
    always_comb begin
        cmd_hit   = reg_we && (reg_addr == OFS_CMD);
        field     = reg_wdata[5:3];
        abort_req = cmd_hit && field[2];
        start_rd  = cmd_hit && reg_wdata[START_BIT] && (field == XFER_READ);
        start_wr  = cmd_hit && reg_wdata[START_BIT] && (field == XFER_WRITE);
        clr_hit   = reg_we && (reg_addr == OFS_STATUS) && reg_wdata[DONE_BIT];
        start_cnt = {1'b0, cnt_reg} + {{CNT_W{1'b0}}, word_mode & cnt_reg[0]};
    end

    // Capture host writes into the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            cnt_reg    <= '0;
            word_mode  <= 1'b0;
            cmd_byte   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_ADDR_LO: start_addr[7:0]  <= reg_wdata;
                OFS_ADDR_HI: start_addr[15:8] <= reg_wdata;
                OFS_CNT_LO:  cnt_reg[7:0]     <= reg_wdata;
                OFS_CNT_HI:  cnt_reg[15:8]    <= reg_wdata;
                OFS_CFG:     word_mode        <= reg_wdata[0];
                OFS_CMD:     cmd_byte         <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Completion flag: set by the engine, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (done_set) done_flag <= 1'b1;
        else if (clr_hit)  done_flag <= 1'b0;
    end

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done_flag);
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !done_set) |=> !done_flag);
endmodule

// File: rtl/rdma_engine.sv
// Transfer engine: walks the current address and remaining count, prefetches
// read data through a one-clock-latency memory, and passes data-port writes
// straight to memory. Commands on the same edge take priority over accesses.
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              abort_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W:0]    start_cnt,
    input  logic              word_mode,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [15:0]       dp_wdata,
    input  logic [15:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done_set,
    output logic              rd_ready,
    output logic [15:0]       rd_data,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata
);
    eng_state_t        state;
    logic [CNT_W:0]    remain;
    logic              wide;
    logic [15:0]       rd_buf;
    logic              cmd_any;
    logic              take;
    logic              last;
    logic [CNT_W:0]    step_c;
    logic [ADDR_W-1:0] step_a;

    // Access acceptance and step sizes for the current transfer.
    always_comb begin
        cmd_any  = start_rd || start_wr || abort_req;
        step_c   = {{(CNT_W-1){1'b0}}, wide, ~wide};
        step_a   = {{(ADDR_W-2){1'b0}}, wide, ~wide};
        take     = !cmd_any && (((state == ENG_READY) && dp_rd) ||
                                ((state == ENG_WRITE) && dp_wr));
        last     = remain <= step_c;
        done_set = (take && last) ||
                   ((start_rd || start_wr) && (start_cnt == '0));
        mem_re   = (state == ENG_FETCH);
        mem_we   = (state == ENG_WRITE) && dp_wr && !cmd_any;
        mem_addr = cur_addr;
        mem_wdata = dp_wdata;
        mem_wide = wide;
        rd_ready = (state == ENG_READY);
        rd_data  = rd_buf;
    end

    // Transfer state, address, count and prefetch buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            wide     <= 1'b0;
            rd_buf   <= '0;
        end else if (abort_req) begin
            state <= ENG_IDLE;
        end else if (start_rd || start_wr) begin
            cur_addr <= start_addr;
            remain   <= start_cnt;
            wide     <= word_mode;
            if (start_cnt == '0) state <= ENG_IDLE;
            else                 state <= start_rd ? ENG_FETCH : ENG_WRITE;
        end else begin
            case (state)
                ENG_FETCH: state <= ENG_WAIT;
                ENG_WAIT: begin
                    rd_buf <= wide ? mem_rdata : {8'h00, mem_rdata[7:0]};
                    state  <= ENG_READY;
                end
                ENG_READY, ENG_WRITE: begin
                    if (take) begin
                        cur_addr <= cur_addr + step_a;
                        remain   <= remain - step_c;
                        if (last)                   state <= ENG_IDLE;
                        else if (state == ENG_READY) state <= ENG_FETCH;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R3 R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_addr == $past(cur_addr) + $past(step_a)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ENG_IDLE) && !start_rd && !start_wr) |=> $stable(cur_addr));
    // R6
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> (state == ENG_IDLE));
    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |-> ($past(state) == ENG_WAIT));
endmodule

// File: rtl/rdma_port_engine.sv
// Top of the remote DMA port engine: joins the register file and the
// transfer engine and provides the combinational register readback.
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic [15:0] dp_wdata,
    output logic [15:0] dp_rdata,
    output logic        dp_rd_ready,
    output logic        done_irq,
    output logic        mem_re,
    output logic        mem_we,
    output logic        mem_wide,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);
    logic              start_rd, start_wr, abort_req, done_set;
    logic              word_mode, done_flag;
    logic [ADDR_W-1:0] start_addr, cur_addr;
    logic [CNT_W:0]    start_cnt;
    logic [7:0]        cmd_byte;

    rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .done_set(done_set), .start_rd(start_rd),
        .start_wr(start_wr), .abort_req(abort_req), .start_addr(start_addr),
        .start_cnt(start_cnt), .word_mode(word_mode), .done_flag(done_flag),
        .cmd_byte(cmd_byte)
    );

    rdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
        .abort_req(abort_req), .start_addr(start_addr), .start_cnt(start_cnt),
        .word_mode(word_mode), .dp_rd(dp_rd), .dp_wr(dp_wr),
        .dp_wdata(dp_wdata), .mem_rdata(mem_rdata), .cur_addr(cur_addr),
        .done_set(done_set), .rd_ready(dp_rd_ready), .rd_data(dp_rdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign done_irq = done_flag;

    // Register readback multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_CMD:     reg_rdata = cmd_byte;
            OFS_STATUS:  reg_rdata = {1'b0, done_flag, 6'b0};
            OFS_ADDR_LO: reg_rdata = cur_addr[7:0];
            OFS_ADDR_HI: reg_rdata = cur_addr[15:8];
            OFS_CFG:     reg_rdata = {7'b0, word_mode};
            default:     reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h8;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0, dp_wr = 1'b0;
    logic [15:0] dp_wdata = 16'h0;
    logic [15:0] dp_rdata;
    logic        dp_rd_ready, done_irq;
    logic        mem_re, mem_we, mem_wide;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'h0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rdma_port_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .dp_rd_ready(dp_rd_ready), .done_irq(done_irq), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Local memory: one-clock read latency, byte or word writes.
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_wide) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
        end
    end

    // Behavioural reference model.
    int   m_sa, m_cnt, m_addr, m_remain, m_wait;
    bit   m_word, m_wide, m_active, m_isrd, m_done;
    logic [7:0]  m_cmd;
    logic [15:0] m_data;

    function automatic logic [7:0] m_peek(input logic [3:0] a);
        case (a)
            4'h0: return m_cmd;
            4'h7: return m_done ? 8'h40 : 8'h00;
            4'h8: return m_addr[7:0];
            4'h9: return m_addr[15:8];
            4'hE: return {7'b0, m_word};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sa = 0; m_cnt = 0; m_addr = 0; m_remain = 0; m_wait = 0;
            m_word = 0; m_wide = 0; m_active = 0; m_isrd = 0; m_done = 0;
            m_cmd = 0; m_data = 0;
        end else if (reg_we) begin
            case (reg_addr)
                4'h8: m_sa = (m_sa & 32'hFF00) | int'(reg_wdata);
                4'h9: m_sa = (m_sa & 32'h00FF) | (int'(reg_wdata) << 8);
                4'hA: m_cnt = (m_cnt & 32'hFF00) | int'(reg_wdata);
                4'hB: m_cnt = (m_cnt & 32'h00FF) | (int'(reg_wdata) << 8);
                4'hE: m_word = reg_wdata[0];
                4'h7: if (reg_wdata[6]) m_done = 0;
                4'h0: begin
                    m_cmd = reg_wdata;
                    if (reg_wdata[5]) m_active = 0;
                    else if (reg_wdata[1] && (reg_wdata[5:3] == 3'd1 || reg_wdata[5:3] == 3'd2)) begin
                        m_remain = m_word ? m_cnt + (m_cnt % 2) : m_cnt;
                        m_addr = m_sa; m_wide = m_word;
                        m_isrd = (reg_wdata[5:3] == 3'd1);
                        m_wait = 2;
                        if (m_remain == 0) begin m_done = 1; m_active = 0; end
                        else m_active = 1;
                    end
                end
                default: ;
            endcase
        end else if (m_active) begin
            if (m_isrd && m_wait == 0) begin
                if (dp_rd) begin
                    m_addr = (m_addr + (m_wide ? 2 : 1)) & 32'hFFFF;
                    m_remain = m_remain - (m_wide ? 2 : 1);
                    m_wait = 2;
                    if (m_remain <= 0) begin m_done = 1; m_active = 0; end
                end
            end else if (m_isrd) begin
                m_wait = m_wait - 1;
                if (m_wait == 0)
                    m_data = m_wide ? {mem[8'(m_addr + 1)], mem[m_addr[7:0]]}
                                    : {8'h00, mem[m_addr[7:0]]};
            end else if (dp_wr) begin
                m_addr = (m_addr + (m_wide ? 2 : 1)) & 32'hFFFF;
                m_remain = m_remain - (m_wide ? 2 : 1);
                if (m_remain <= 0) begin m_done = 1; m_active = 0; end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs to the model 5 ns after every rising edge.
    always @(posedge clk) begin
        #5;
        cycles++;
        chk("R7 done_irq", int'(done_irq), int'(m_done));
        chk("R5 dp_rd_ready", int'(dp_rd_ready), int'(m_active && m_isrd && m_wait == 0));
        if (m_active && m_isrd && m_wait == 0) chk("R5 dp_rdata", int'(dp_rdata), int'(m_data));
        chk("R6 mem_we", int'(mem_we), int'(dp_wr && m_active && !m_isrd && !reg_we));
        if (mem_we) begin
            chk("R6 mem_addr", int'(mem_addr), m_addr);
            chk("R6 mem_wdata", int'(mem_wdata), int'(dp_wdata));
        end
        chk("R2 reg_rdata", int'(reg_rdata), int'(m_peek(reg_addr)));
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_addr = 4'h8;
    endtask
    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #1 v = reg_rdata;
    endtask
    task automatic wait_ready();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dp_rd_ready) break;
        end
    endtask
    task automatic dprd();
        @(negedge clk); dp_rd = 1;
        @(negedge clk); dp_rd = 0;
    endtask
    task automatic dpwr(input logic [15:0] d);
        @(negedge clk); dp_wr = 1; dp_wdata = d;
        @(negedge clk); dp_wr = 0;
    endtask
    task automatic setup(input logic [15:0] sa, input logic [15:0] cnt, input logic word);
        wr(4'hE, {7'b0, word});
        wr(4'h8, sa[7:0]); wr(4'h9, sa[15:8]);
        wr(4'hA, cnt[7:0]); wr(4'hB, cnt[15:8]);
    endtask

    logic [7:0] v;
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        peek(4'h7, v); chk("R12 status", int'(v), 0);
        peek(4'h8, v); chk("R12 addr", int'(v), 0);

        // R1 R3 byte read of 3
        setup(16'h0010, 16'd3, 1'b0);
        wr(4'h0, 8'h0A);
        wait_ready(); chk("R1 read started", int'(dp_rd_ready), 1);
        for (int k = 0; k < 3; k++) begin wait_ready(); dprd(); end
        peek(4'h8, v); chk("R3 addr lo", int'(v), 8'h13);
        peek(4'h9, v); chk("R3 addr hi", int'(v), 8'h00);
        peek(4'h7, v); chk("R7 status set", int'(v), 8'h40);
        wr(4'h7, 8'h00); peek(4'h7, v); chk("R8 zero write keeps", int'(v), 8'h40);
        wr(4'h7, 8'h40); peek(4'h7, v); chk("R8 w1c clears", int'(v), 8'h00);

        // R4 word read, odd count 5 rounds to 6
        setup(16'h0120, 16'd5, 1'b1);
        wr(4'h0, 8'h0A);
        for (int k = 0; k < 3; k++) begin wait_ready(); dprd(); end
        peek(4'h8, v); chk("R4 addr lo", int'(v), 8'h26);
        peek(4'h9, v); chk("R4 addr hi", int'(v), 8'h01);
        peek(4'h7, v); chk("R4 done after three words", int'(v), 8'h40);
        wr(4'h7, 8'h40);

        // R6 byte write of 2
        setup(16'h0050, 16'd2, 1'b0);
        wr(4'h0, 8'h12);
        dpwr(16'h00AB); dpwr(16'h00CD);
        chk("R6 byte0", int'(mem[8'h50]), 8'hAB);
        chk("R6 byte1", int'(mem[8'h51]), 8'hCD);
        peek(4'h8, v); chk("R3 write addr", int'(v), 8'h52);

        // R4 R6 word write, count 3 rounds to 4
        setup(16'h0060, 16'd3, 1'b1);
        wr(4'h0, 8'h12);
        dpwr(16'h1234); dpwr(16'h5678);
        chk("R6 w0", int'({mem[8'h61], mem[8'h60]}), 16'h1234);
        chk("R6 w1", int'({mem[8'h63], mem[8'h62]}), 16'h5678);
        peek(4'h7, v); chk("R4 word write done", int'(v), 8'h40);
        wr(4'h7, 8'h40);

        // R9 abort mid transfer
        setup(16'h0070, 16'd10, 1'b0);
        wr(4'h0, 8'h0A);
        wait_ready(); dprd();
        wr(4'h0, 8'h20);
        dprd();
        peek(4'h8, v); chk("R9 addr frozen", int'(v), 8'h71);
        peek(4'h7, v); chk("R9 no done", int'(v), 8'h00);
        chk("R9 not ready", int'(dp_rd_ready), 0);

        // R10 idle access ignored
        dpwr(16'h00EE);
        chk("R10 mem untouched", int'(mem[8'h71]), int'(8'h71 ^ 8'h5A));
        peek(4'h8, v); chk("R10 addr held", int'(v), 8'h71);

        // R11 field 011 starts nothing
        setup(16'h0080, 16'd4, 1'b0);
        wr(4'h0, 8'h1A);
        repeat (4) @(negedge clk);
        chk("R11 no ready", int'(dp_rd_ready), 0);
        dpwr(16'h0011);
        chk("R11 mem untouched", int'(mem[8'h80]), int'(8'h80 ^ 8'h5A));
        peek(4'h8, v); chk("R11 addr not loaded", int'(v), 8'h71);

        // R7 zero count start
        setup(16'h0090, 16'd0, 1'b0);
        wr(4'h0, 8'h0A);
        peek(4'h7, v); chk("R7 zero count done", int'(v), 8'h40);
        chk("R7 zero count idle", int'(dp_rd_ready), 0);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule